// File: doc/BRIEF.md
# Edge-Interrupt GPIO Register Block

This block is an eight-line general-purpose I/O controller reached through a byte-wide register bus. Every line has an output latch bit and a direction bit. A direction bit of 1 drives the line. A direction bit of 0 leaves the line as an input. Software can change the direction of each line at any time. Reading the data register returns the synchronised pad levels. It never returns the output latch, so an earlier output value cannot be read back.

The upper lines can raise interrupts. Every such line owns two sticky flags: one for rising edges and one for falling edges. Both flags latch their edge at all times. A two-bit code per line in the configuration register only chooses which flag shows in the status register and feeds the single interrupt output. Writing a 1 to a status bit clears both flags of that line. An edge that lands in the same cycle as the clear is kept. Software can therefore clear a status bit, sample the pin and reprogram the edge without losing an event.

The register bus is plain control: a write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from the current state. There is no back-pressure.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the data latch, direction, configuration and all edge flags are zero, so `pin_out`, `pin_oe` and `irq` are low and every register reads 0.
- R2: The direction register at offset 1 has one bit per line (1 = output). It appears on `pin_oe` after the writing edge and reads back unchanged.
- R3: A write to offset 0 sets `pin_out` after the writing edge, and `pin_out` holds otherwise. A read of offset 0 returns `pin_in` after two synchroniser stages, never the latch.
- R4: The configuration register at offset 3 holds a two-bit code for interrupt input i at bits 2i+1:2i. The codes are 00 = none, 01 = falling, 10 = rising and 11 = none. The register reads back as written.
- R5: Rising and falling flags latch their edges whatever code is configured. Switching the code later reveals an edge that was latched earlier.
- R6: Reading offset 4 returns, at bit i, the flag selected for interrupt input i, which is line i+4. Bits with code 00 or 11 read 0.
- R7: Writing offset 4 with bit i = 1 clears both the rising and the falling flag of input i. A 0 bit leaves that input's flags unchanged.
- R8: An edge detected in the same cycle as a clear of its input leaves that flag set.
- R9: `irq` is high exactly when some status bit reads 1.
- R10: Offsets 2, 5, 6 and 7 read 0, and writes to them change no register.
- R11: Edges on the output-only lines 0 to 3 never set a status bit or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| pin_in | input | 8 | Pad levels |
| pin_out | output | 8 | Output latch |
| pin_oe | output | 8 | Output enable per line |
| irq | output | 1 | OR of the visible status bits |

## Verification
The bench builds the block with its default parameters: eight lines, four of them output-only, and a two-stage synchroniser. With these values one configuration byte holds all four trigger codes at once, so a single write covers the none, falling, rising and reserved codes. The split between output-only and interrupt lines also exercises the index shift from interrupt input to pin. The fixed synchroniser depth lets the bench time the clear-versus-edge collision to the exact cycle.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int OFS_DATA = 0;
  localparam int OFS_DIR  = 1;
  localparam int OFS_CFG  = 3;
  localparam int OFS_STAT = 4;

  typedef enum logic [1:0] {
    TRIG_NONE    = 2'b00,
    TRIG_FALL    = 2'b01,
    TRIG_RISE    = 2'b10,
    TRIG_NONE_HI = 2'b11
  } trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_cell.sv
module gpio_edge_cell
  import gpio_edge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       visible
);
  logic prev_q, rise_q, fall_q;
  logic rise_det, fall_det;

  assign rise_det = lvl & ~prev_q;
  assign fall_det = ~lvl & prev_q;

  // a fresh edge outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      rise_q <= rise_det | (rise_q & ~clr);
      fall_q <= fall_det | (fall_q & ~clr);
    end
  end

  always_comb begin
    case (trig_e'(sel))
      TRIG_FALL: visible = fall_q;
      TRIG_RISE: visible = rise_q;
      default:   visible = 1'b0;
    endcase
  end

  assert_vis_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    visible |-> (sel == 2'b01 || sel == 2'b10));
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_q && !clr) |=> rise_q);
  assert_clear_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rise_det && !fall_det) |=> (!rise_q && !fall_q));
  assert_edge_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_det && clr) |=> rise_q);
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int NUM_LINES    = 8,
  parameter int NUM_OUT_ONLY = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int ADDR_W       = 3,
  parameter int BUS_W        = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe,
  output logic                 irq
);
  localparam int NUM_IRQ = NUM_LINES - NUM_OUT_ONLY;
  localparam int CFG_W   = 2 * NUM_IRQ;

  logic [NUM_LINES-1:0] out_q, dir_q, pin_lvl;
  logic [CFG_W-1:0]     cfg_q;
  logic [NUM_IRQ-1:0]   stat_vis, stat_clr;
  logic                 wr_en;

  assign wr_en = bus_sel & bus_wr;

  gpio_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      cfg_q <= '0;
    end else if (wr_en) begin
      if (bus_addr == ADDR_W'(OFS_DATA)) out_q <= bus_wdata[NUM_LINES-1:0];
      if (bus_addr == ADDR_W'(OFS_DIR))  dir_q <= bus_wdata[NUM_LINES-1:0];
      if (bus_addr == ADDR_W'(OFS_CFG))  cfg_q <= bus_wdata[CFG_W-1:0];
    end
  end

  assign stat_clr = (wr_en && bus_addr == ADDR_W'(OFS_STAT)) ?
                    bus_wdata[NUM_IRQ-1:0] : '0;

  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_irq_line
    gpio_edge_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (pin_lvl[NUM_OUT_ONLY+gi]),
      .clr    (stat_clr[gi]),
      .sel    (cfg_q[2*gi +: 2]),
      .visible(stat_vis[gi])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_DATA))      bus_rdata = BUS_W'(pin_lvl);
    else if (bus_addr == ADDR_W'(OFS_DIR))  bus_rdata = BUS_W'(dir_q);
    else if (bus_addr == ADDR_W'(OFS_CFG))  bus_rdata = BUS_W'(cfg_q);
    else if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = BUS_W'(stat_vis);
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |stat_vis;

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && bus_addr == ADDR_W'(OFS_DATA)) |=> $stable(pin_out));
  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && bus_addr == ADDR_W'(OFS_DIR)) |=> $stable(pin_oe));
  assert_irq_needs_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cfg_q != '0));
endmodule

// File: tb/gpio_edge_irq_bench.sv
module gpio_edge_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pin_in = '0, pin_out, pin_oe;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  gpio_edge_irq u_gpio_edge_irq (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // monitor: compares each read against the scoreboard queue
  always @(negedge clk) begin
    logic [7:0] e;
    string t;
    if (rst_n && bus_sel && !bus_wr) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %h expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 reset state
    chk(pin_out, 8'h00, "R1 pin_out");
    chk(pin_oe, 8'h00, "R1 pin_oe");
    chk({7'd0, irq}, 8'h00, "R1 irq");
    rd(3'd0, 8'h00, "R1 data");
    rd(3'd1, 8'h00, "R1 dir");
    rd(3'd3, 8'h00, "R1 cfg");
    rd(3'd4, 8'h00, "R1 status");
    // R2 direction
    wr(3'd1, 8'hA5);
    chk(pin_oe, 8'hA5, "R2 pin_oe");
    rd(3'd1, 8'hA5, "R2 readback");
    // R3 output latch vs pad read
    wr(3'd0, 8'h3C);
    chk(pin_out, 8'h3C, "R3 pin_out");
    pin_in = 8'h05;
    wait_cyc(4);
    rd(3'd0, 8'h05, "R3 data reads pads");
    // R10 unused offsets
    wr(3'd2, 8'hFF); wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd2, 8'h00, "R10 ofs2"); rd(3'd5, 8'h00, "R10 ofs5");
    rd(3'd6, 8'h00, "R10 ofs6"); rd(3'd7, 8'h00, "R10 ofs7");
    rd(3'd1, 8'hA5, "R10 dir kept"); rd(3'd3, 8'h00, "R10 cfg kept");
    chk(pin_out, 8'h3C, "R10 pin_out kept");
    // R4/R6 codes: in3=11 in2=rise in1=fall in0=none
    wr(3'd3, 8'hE4);
    rd(3'd3, 8'hE4, "R4 cfg readback");
    pin_in = 8'hF5;
    wait_cyc(4);
    rd(3'd4, 8'h04, "R6 only rise-coded input visible");
    chk({7'd0, irq}, 8'h01, "R9 irq high");
    // R5 latched rise revealed by reconfiguring
    wr(3'd3, 8'h28);
    rd(3'd4, 8'h06, "R5 in1 rise revealed");
    wr(3'd3, 8'hAA);
    rd(3'd4, 8'h0F, "R5 all rise flags");
    // R7 clear
    wr(3'd4, 8'h01);
    rd(3'd4, 8'h0E, "R7 clear bit0");
    wr(3'd4, 8'h00);
    rd(3'd4, 8'h0E, "R7 zero write no effect");
    wr(3'd4, 8'h0F);
    rd(3'd4, 8'h00, "R7 clear all");
    chk({7'd0, irq}, 8'h00, "R9 irq low");
    // R7 both flags cleared by one write
    pin_in = 8'h05; wait_cyc(4);
    pin_in = 8'hF5; wait_cyc(4);
    wr(3'd3, 8'h55);
    rd(3'd4, 8'h0F, "R6 falling flags");
    wr(3'd4, 8'h0F);
    rd(3'd4, 8'h00, "R7 fall cleared");
    wr(3'd3, 8'hAA);
    rd(3'd4, 8'h00, "R7 rise cleared too");
    // R8 edge collides with clear
    pin_in = 8'h75; wait_cyc(4);
    wr(3'd4, 8'h0F);
    rd(3'd4, 8'h00, "R8 setup");
    pin_in = 8'hF5;
    wait_cyc(2);
    wr(3'd4, 8'h08);
    wait_cyc(3);
    rd(3'd4, 8'h08, "R8 edge kept over clear");
    chk({7'd0, irq}, 8'h01, "R8 irq");
    wr(3'd4, 8'h08);
    rd(3'd4, 8'h00, "R8 cleared after");
    // R11 output-only lines
    pin_in = 8'hFA; wait_cyc(4);
    rd(3'd4, 8'h00, "R11 low lines no status");
    chk({7'd0, irq}, 8'h00, "R11 irq");
    rd(3'd0, 8'hFA, "R3 data pads");
    wr(3'd1, 8'h0F);
    chk(pin_oe, 8'h0F, "R2 dir change");
    wait_cyc(2);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    report();
  end
endmodule